// File: doc/BRIEF.md
# Predicated Split-Constant Register Writer

This block holds a bank of 32 general registers, each 32 bits wide. It builds 32-bit constants from two 16-bit immediate operations. The lower half of the bank (indices 0 to 15) is the A side and the upper half (indices 16 to 31) is the B side. The "set-low" operation writes a 16-bit immediate and fills the upper 16 bits with copies of its bit 15. The "set-high" operation replaces only bits 31:16 and leaves bits 15:0 unchanged. Issuing set-low and then set-high therefore gives a full 32-bit constant. Issuing them in the opposite order loses the high half.

Any operation may carry a predicate. When prediction is enabled, the operation runs only if the chosen condition register is nonzero. If the invert bit is also set, it runs only if that register is zero. Only five registers can serve as conditions. Any other select code is illegal: the write is dropped and an error flag is raised. The block has two combinational read ports that software or a neighbouring unit can use to observe the bank.

Top module: `cmov_writer`

## Requirements
- R1: While reset is low and after it is released, every register reads 0 and `errFlag` is 0.
- R2: A set-low (`opCode` = 2'b01) writes the immediate into bits 15:0 and copies bit 15 into bits 31:16. For example, 0xFABC becomes 0xFFFFFABC and 0x1234 becomes 0x00001234.
- R3: A set-high (`opCode` = 2'b10) writes the immediate into bits 31:16 and keeps bits 15:0. For example, 0x87654321 with immediate 0x1234 becomes 0x12344321.
- R4: A set-low of 0xFABC followed by a set-high of 0x1234 gives 0x1234FABC. The same two operations in the opposite order give 0xFFFFFABC.
- R5: `dstIdx` values 0 to 15 select A0 to A15 and values 16 to 31 select B0 to B15. A write changes only the selected register.
- R6: With `predEn` = 0 the operation always runs. The `predSel` codes 0, 1, 2, 3 and 4 select A1, A2, B0, B1 and B2 (register indices 1, 2, 16, 17 and 18).
- R7: With `predEn` = 1 and a legal select, the operation runs if the condition register is nonzero and `predInv` = 0, or if it is zero and `predInv` = 1. Otherwise the destination is left unchanged. The condition is read before the same edge's write.
- R8: With `predEn` = 1, a set-low or set-high whose `predSel` is 5, 6 or 7 writes nothing and sets `errFlag` for the cycle after that edge. With `predEn` = 0, the select code is ignored and no error is raised.
- R9: `opCode` 2'b00 and 2'b11 write no register and raise no error.
- R10: Writes take effect on the rising clock edge. Both read ports reflect the bank combinationally and independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opCode | input | 2 | 00 idle, 01 set-low, 10 set-high, 11 idle |
| dstIdx | input | 5 | Destination register index |
| imm | input | 16 | Immediate half-word |
| predEn | input | 1 | Enable predication |
| predSel | input | 3 | Condition register select code |
| predInv | input | 1 | Execute on zero instead of nonzero |
| rdIdxA | input | 5 | Read port A index |
| rdDataA | output | 32 | Read port A data |
| rdIdxB | input | 5 | Read port B index |
| rdDataB | output | 32 | Read port B data |
| errFlag | output | 1 | Illegal predicate select was seen on the previous edge |

## Verification
An operation presented before rising edge k changes its destination at edge k. Its effect on the read ports and on `errFlag` can therefore be observed anywhere between edge k and edge k+1. The driver applies each operation on a falling edge and updates its model at the rising edge. It then queues the expected destination value and the expected error bit. The monitor reads these items back through read port B on the next falling edge, before the following write can land. Read port A is used separately for the reset sweep and for the check that a read is available in the same cycle.

// File: rtl/cmov_pkg.sv
package cmov_pkg;
  localparam int DATA_W   = 32;
  localparam int IMM_W    = 16;
  localparam int NUM_REGS = 32;
  localparam int HALF     = NUM_REGS / 2;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int NUM_PRED = 5;
  localparam int PSEL_W   = 3;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_SETLO = 2'b01,
    OP_SETHI = 2'b10,
    OP_RSVD  = 2'b11
  } opKind_t;

  typedef struct packed {
    logic             wrEn;
    logic             selHigh;
    logic [IDX_W-1:0] dstIdx;
    logic [IMM_W-1:0] imm;
  } wrStrobe_t;

  // Map a condition select code to its register index: two on the A side, three on the B side.
  function automatic logic [IDX_W-1:0] predRegIdx(input int k);
    case (k)
      0:       predRegIdx = IDX_W'(1);
      1:       predRegIdx = IDX_W'(2);
      2:       predRegIdx = IDX_W'(HALF);
      3:       predRegIdx = IDX_W'(HALF + 1);
      default: predRegIdx = IDX_W'(HALF + 2);
    endcase
  endfunction
endpackage

// File: rtl/cmov_ctrl.sv
module cmov_ctrl
  import cmov_pkg::*;
#(
  parameter int D_W    = DATA_W,
  parameter int I_W    = IMM_W,
  parameter int X_W    = IDX_W,
  parameter int S_W    = PSEL_W,
  parameter int N_PRED = NUM_PRED
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [1:0]                opCode,
  input  logic [X_W-1:0]            dstIdx,
  input  logic [I_W-1:0]            imm,
  input  logic                      predEn,
  input  logic [S_W-1:0]            predSel,
  input  logic                      predInv,
  input  logic [N_PRED-1:0][D_W-1:0] predVals,
  output wrStrobe_t                 wrStb,
  output logic                      errFlag
);
  logic isMove;
  logic selLegal;
  logic predTrue;
  logic condOk;
  logic badSel;
  logic [N_PRED-1:0] predNz;

  for (genvar k = 0; k < N_PRED; k++) begin : g_nz
    assign predNz[k] = |predVals[k];
  end

  always_comb begin
    predTrue = 1'b0;
    for (int k = 0; k < N_PRED; k++) begin
      if (int'(predSel) == k) predTrue = predNz[k];
    end
  end

  assign isMove   = (opCode == OP_SETLO) || (opCode == OP_SETHI);
  assign selLegal = int'(predSel) < N_PRED;
  assign condOk   = !predEn || (selLegal && (predTrue ^ predInv));
  assign badSel   = isMove && predEn && !selLegal;

  always_comb begin
    wrStb.wrEn    = isMove && condOk;
    wrStb.selHigh = (opCode == OP_SETHI);
    wrStb.dstIdx  = dstIdx;
    wrStb.imm     = imm;
  end

  always_ff @(posedge clk) begin
    if (!rstN) errFlag <= 1'b0;
    else       errFlag <= badSel;
  end

  // R8
  err_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (predEn && isMove && int'(predSel) >= N_PRED) |=> errFlag);
  // R8
  err_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (predEn && int'(predSel) >= N_PRED) |-> !wrStb.wrEn);
  // R9
  idle_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_IDLE || opCode == OP_RSVD) |-> !wrStb.wrEn);
  // R6
  unpred_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!predEn && isMove) |-> wrStb.wrEn);
endmodule

// File: rtl/cmov_regbank.sv
module cmov_regbank
  import cmov_pkg::*;
#(
  parameter int D_W    = DATA_W,
  parameter int I_W    = IMM_W,
  parameter int N_REG  = NUM_REGS,
  parameter int X_W    = IDX_W,
  parameter int N_PRED = NUM_PRED
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  wrStrobe_t                  wrStb,
  input  logic [X_W-1:0]             rdIdxA,
  input  logic [X_W-1:0]             rdIdxB,
  output logic [D_W-1:0]             rdDataA,
  output logic [D_W-1:0]             rdDataB,
  output logic [N_PRED-1:0][D_W-1:0] predVals
);
  localparam int EXT_W = D_W - I_W;

  logic [N_REG-1:0][D_W-1:0] regs;
  logic [D_W-1:0]            curVal;
  logic [D_W-1:0]            newVal;

  assign curVal = regs[wrStb.dstIdx];

  always_comb begin
    if (wrStb.selHigh) newVal = {wrStb.imm, curVal[I_W-1:0]};
    else               newVal = {{EXT_W{wrStb.imm[I_W-1]}}, wrStb.imm};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regs <= '0;
    end else if (wrStb.wrEn) begin
      regs[wrStb.dstIdx] <= newVal;
    end
  end

  assign rdDataA = regs[rdIdxA];
  assign rdDataB = regs[rdIdxB];

  for (genvar k = 0; k < N_PRED; k++) begin : g_tap
    assign predVals[k] = regs[predRegIdx(k)];
  end

  // R2
  lowsext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.wrEn && !wrStb.selHigh) |=>
      regs[$past(wrStb.dstIdx)] == {{EXT_W{$past(wrStb.imm[I_W-1])}}, $past(wrStb.imm)});
  // R3
  highkeep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.wrEn && wrStb.selHigh) |=>
      regs[$past(wrStb.dstIdx)] == {$past(wrStb.imm), $past(curVal[I_W-1:0])});
  // R7
  nowrite_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrStb.wrEn |=> $stable(regs));
endmodule

// File: rtl/cmov_writer.sv
module cmov_writer
  import cmov_pkg::*;
#(
  parameter int D_W    = DATA_W,
  parameter int I_W    = IMM_W,
  parameter int N_REG  = NUM_REGS,
  parameter int X_W    = IDX_W,
  parameter int S_W    = PSEL_W,
  parameter int N_PRED = NUM_PRED
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [1:0]     opCode,
  input  logic [X_W-1:0] dstIdx,
  input  logic [I_W-1:0] imm,
  input  logic           predEn,
  input  logic [S_W-1:0] predSel,
  input  logic           predInv,
  input  logic [X_W-1:0] rdIdxA,
  output logic [D_W-1:0] rdDataA,
  input  logic [X_W-1:0] rdIdxB,
  output logic [D_W-1:0] rdDataB,
  output logic           errFlag
);
  wrStrobe_t                 wrStb;
  logic [N_PRED-1:0][D_W-1:0] predVals;

  cmov_ctrl #(
    .D_W(D_W), .I_W(I_W), .X_W(X_W), .S_W(S_W), .N_PRED(N_PRED)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .opCode(opCode), .dstIdx(dstIdx), .imm(imm),
    .predEn(predEn), .predSel(predSel), .predInv(predInv),
    .predVals(predVals), .wrStb(wrStb), .errFlag(errFlag)
  );

  cmov_regbank #(
    .D_W(D_W), .I_W(I_W), .N_REG(N_REG), .X_W(X_W), .N_PRED(N_PRED)
  ) u_bank (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdIdxA(rdIdxA), .rdIdxB(rdIdxB),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .predVals(predVals)
  );
endmodule

// File: tb/sim_cmov_writer.sv
`timescale 1ns/1ps
module sim_cmov_writer;
  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  opCode;
  logic [4:0]  dstIdx;
  logic [15:0] imm;
  logic        predEn;
  logic [2:0]  predSel;
  logic        predInv;
  logic [4:0]  rdIdxA;
  logic [31:0] rdDataA;
  logic [4:0]  rdIdxB;
  logic [31:0] rdDataB;
  logic        errFlag;

  always #4 clk = ~clk;

  cmov_writer u0 (
    .clk(clk), .rstN(rstN), .opCode(opCode), .dstIdx(dstIdx), .imm(imm),
    .predEn(predEn), .predSel(predSel), .predInv(predInv),
    .rdIdxA(rdIdxA), .rdDataA(rdDataA), .rdIdxB(rdIdxB), .rdDataB(rdDataB),
    .errFlag(errFlag)
  );

  typedef struct {
    logic [4:0]  idx;
    logic [31:0] val;
    logic        err;
    string       tag;
  } item_t;

  item_t       q[$];
  logic [31:0] model[32];
  int          total = 0;
  int          bad = 0;
  bit          done = 0;

  function automatic int condIdx(input int s);
    case (s)
      0: return 1;
      1: return 2;
      2: return 16;
      3: return 17;
      default: return 18;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Driver: called on a falling edge, returns on the next falling edge.
  task automatic doOp(input string tag, input logic [1:0] op, input int dst,
                      input logic [15:0] iv, input bit pen, input int psel,
                      input bit pinv, input int chkIdx);
    bit    move, legal, run, errExp;
    item_t it;
    opCode = op; dstIdx = dst[4:0]; imm = iv;
    predEn = pen; predSel = psel[2:0]; predInv = pinv;
    move   = (op == 2'b01) || (op == 2'b10);
    legal  = psel < 5;
    errExp = move && pen && !legal;
    run    = move && (!pen || (legal && ((model[condIdx(psel)] != 0) ^ pinv)));
    @(posedge clk);
    if (run) begin
      if (op == 2'b01) model[dst] = {{16{iv[15]}}, iv};
      else             model[dst] = {iv, model[dst][15:0]};
    end
    #1;
    it.idx = dst[4:0]; it.val = model[dst]; it.err = errExp; it.tag = tag;
    q.push_back(it);
    if (chkIdx >= 0) begin
      it.idx = chkIdx[4:0]; it.val = model[chkIdx]; it.tag = {tag, "_other"};
      q.push_back(it);
    end
    @(negedge clk);
    opCode = 2'b00;
  endtask

  // Monitor: reads each queued register back through port B.
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        it = q.pop_front();
        rdIdxB = it.idx;
        #1;
        check(it.tag, rdDataB, it.val);
        check({it.tag, "_err"}, {31'b0, errFlag}, {31'b0, it.err});
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; opCode = 2'b00; dstIdx = '0; imm = '0; predEn = 0;
    predSel = '0; predInv = 0; rdIdxA = '0; rdIdxB = '0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset sweep through port A
    for (int i = 0; i < 32; i++) begin
      rdIdxA = i[4:0]; #1;
      check("R1_reg", rdDataA, 32'h0);
    end
    check("R1_err", {31'b0, errFlag}, 32'h0);
    @(negedge clk);

    doOp("R2_neg", 2'b01, 5, 16'hFABC, 0, 0, 0, -1);
    doOp("R2_pos", 2'b01, 6, 16'h1234, 0, 0, 0, -1);
    doOp("R4_lo", 2'b01, 7, 16'h4321, 0, 0, 0, -1);
    doOp("R4_hi", 2'b10, 7, 16'h8765, 0, 0, 0, -1);
    doOp("R3_merge", 2'b10, 7, 16'h1234, 0, 0, 0, -1);
    doOp("R4_ok_lo", 2'b01, 20, 16'hFABC, 0, 0, 0, -1);
    doOp("R4_ok_hi", 2'b10, 20, 16'h1234, 0, 0, 0, -1);
    doOp("R4_rev_hi", 2'b10, 19, 16'h1234, 0, 0, 0, -1);
    doOp("R4_rev_lo", 2'b01, 19, 16'hFABC, 0, 0, 0, -1);
    doOp("R5_b15", 2'b01, 31, 16'h00AA, 0, 0, 0, 15);
    doOp("R5_a15", 2'b01, 15, 16'h7001, 0, 0, 0, 31);

    // R7 and R6: A1 is zero here
    doOp("R7_zero_skip", 2'b01, 8, 16'h1111, 1, 0, 0, -1);
    doOp("R7_zero_inv", 2'b01, 8, 16'h2222, 1, 0, 1, -1);
    doOp("R6_seta1", 2'b01, 1, 16'h0001, 0, 0, 0, -1);
    doOp("R7_nz_run", 2'b01, 9, 16'h3333, 1, 0, 0, -1);
    doOp("R7_nz_inv_skip", 2'b01, 9, 16'h4444, 1, 0, 1, -1);
    doOp("R6_setb1", 2'b10, 17, 16'h8000, 0, 0, 0, -1);
    doOp("R6_sel_b1", 2'b01, 10, 16'h5555, 1, 3, 0, -1);
    doOp("R6_sel_b2", 2'b01, 11, 16'h6666, 1, 4, 0, -1);
    doOp("R6_sel_b0", 2'b10, 12, 16'h7777, 1, 2, 1, -1);
    doOp("R6_sel_a2", 2'b01, 13, 16'h9999, 1, 1, 0, -1);
    doOp("R6_seta2", 2'b01, 2, 16'hFFFF, 0, 0, 0, -1);
    doOp("R6_sel_a2b", 2'b01, 13, 16'hABCD, 1, 1, 0, -1);

    // R8 illegal selects
    doOp("R8_bad5", 2'b01, 14, 16'hDEAD, 1, 5, 0, -1);
    doOp("R8_bad7inv", 2'b10, 14, 16'hBEEF, 1, 7, 1, -1);
    doOp("R8_clear", 2'b01, 21, 16'h0042, 1, 0, 0, -1);
    doOp("R8_ignored", 2'b01, 22, 16'h0043, 0, 6, 0, -1);

    // R9 idle codes
    doOp("R9_idle", 2'b00, 5, 16'h0000, 0, 0, 0, -1);
    doOp("R9_rsvd", 2'b11, 7, 16'h5A5A, 1, 6, 0, -1);

    // R10 both ports combinational and independent
    doOp("R10_wr", 2'b01, 23, 16'h0ACE, 0, 0, 0, -1);
    rdIdxA = 5'd23; #1;
    check("R10_portA", rdDataA, 32'h00000ACE);
    rdIdxA = 5'd7; #1;
    check("R10_portA2", rdDataA, 32'h12344321);

    repeat (3) @(negedge clk);
    check("R1_queue_empty", q.size(), 32'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule